// File: doc/BRIEF.md
# Hybrid Priority / Round-Robin Channel Arbiter

This arbiter picks the channel that gets the next DMA service slot for one direction of a multichannel packet buffer. Each of up to 256 channels raises a request bit. A 2-bit mode input splits the channels into two groups. The lowest-numbered channels form a strict-priority group, and the rest are served in round-robin order. Externally the channels are numbered 1..256. On the ports, channel k is request bit k-1 and grant index k-1.

The grant is combinational from the current requests, the mode and a registered round-robin pointer. It is presented as a valid strobe, a one-hot vector and an encoded index. The DMA engine acknowledges a grant in the same cycle. An acknowledge of a round-robin grant moves the pointer just past the granted channel. The receive and transmit directions each use their own instance with their own mode bits.

Top module: `hybrid_arb`

## Requirements
- R1: With mode 0, no channel is in strict priority, and all channels (indices 0..255) are served round-robin.
- R2: With mode 1, indices 0 and 1 (channels 1 and 2) are in strict priority, and indices 2..255 are round-robin.
- R3: With mode 2, indices 0..15 are in strict priority, and indices 16..255 are round-robin.
- R4: With mode 3, indices 0..63 are in strict priority, and indices 64..255 are round-robin.
- R5: Within the strict-priority group, the requesting channel with the lowest index is granted.
- R6: Any request in the strict-priority group wins over every round-robin request.
- R7: Among round-robin requests, the grant goes to the first requesting index at or above the pointer. If none is found there, the search wraps to the lowest round-robin index. A pointer below the round-robin group is treated as the group's first index.
- R8: The pointer changes only in a cycle where `ack_i` is high while a round-robin grant is shown. It then becomes the granted index plus one, or the first round-robin index when index 255 was granted. An acknowledged strict-priority grant leaves the pointer unchanged.
- R9: With no request active, `gnt_valid_o` is low and `gnt_oh_o` is all zero.
- R10: When `gnt_valid_o` is high, `gnt_oh_o` has exactly one bit set, at position `gnt_idx_o`, and that request bit is active.
- R11: Reset puts the pointer at index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Size of the strict-priority group: 0 none, 1 two, 2 sixteen, 3 sixty-four |
| req_i | input | 256 | Service request per channel, bit k-1 for channel k |
| ack_i | input | 1 | Grant taken by the DMA engine this cycle |
| gnt_valid_o | output | 1 | A grant is present |
| gnt_idx_o | output | 8 | Encoded granted index (channel minus one) |
| gnt_oh_o | output | 256 | One-hot grant |

## Verification
The assertions check these properties on every cycle:
- the grant is well formed and points at a live request;
- there is no grant when no request is active;
- a strict request always beats the round-robin group;
- no strict grant has a lower requester;
- the pointer moves only on an acknowledged round-robin grant, to the right next index.

Some behaviour needs the bench's reference model to show:
- which round-robin channel should win for a given pointer;
- the wrap from index 255 back to the first round-robin index under each mode;
- a pointer left below the group after a mode change.

// File: rtl/hybrid_arb_pkg.sv
`timescale 1ns/1ps
package hybrid_arb_pkg;

  typedef enum logic [1:0] {
    MODE_RR_ALL  = 2'd0,
    MODE_PRI_LO  = 2'd1,
    MODE_PRI_MID = 2'd2,
    MODE_PRI_HI  = 2'd3
  } arb_mode_e;

  // number of strict-priority channels for a mode
  function automatic int pri_span(input logic [1:0] mode, input int n1, input int n2, input int n3);
    case (arb_mode_e'(mode))
      MODE_PRI_LO:  return n1;
      MODE_PRI_MID: return n2;
      MODE_PRI_HI:  return n3;
      default:      return 0;
    endcase
  endfunction

endpackage

// File: rtl/arb_first_set.sv
`timescale 1ns/1ps
module arb_first_set #(
  parameter int W = 256
) (
  input  logic [W-1:0]         vec_i,
  output logic                 found_o,
  output logic [$clog2(W)-1:0] idx_o
);
  localparam int IW = $clog2(W);

  // scan downward so the lowest set bit is kept last
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/arb_rr_ptr.sv
`timescale 1ns/1ps
module arb_rr_ptr #(
  parameter int N_CH = 256,
  localparam int IW  = $clog2(N_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [IW-1:0] gnt_idx_i,
  input  logic [IW-1:0] base_i,
  output logic [IW-1:0] ptr_o
);
  logic [IW-1:0] ptr_d;

  always_comb begin
    if (gnt_idx_i == IW'(N_CH - 1)) ptr_d = base_i;
    else                            ptr_d = gnt_idx_i + IW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= ptr_d;
  end
endmodule

// File: rtl/hybrid_arb.sv
`timescale 1ns/1ps
module hybrid_arb #(
  parameter int N_CH   = 256,
  parameter int PRI_N1 = 2,
  parameter int PRI_N2 = 16,
  parameter int PRI_N3 = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              mode_i,
  input  logic [N_CH-1:0]         req_i,
  input  logic                    ack_i,
  output logic                    gnt_valid_o,
  output logic [$clog2(N_CH)-1:0] gnt_idx_o,
  output logic [N_CH-1:0]         gnt_oh_o
);
  localparam int IW = $clog2(N_CH);

  logic [IW:0]     pri_n;
  logic [IW-1:0]   base;
  logic [IW-1:0]   ptr_q;
  logic [IW-1:0]   ptr_eff;
  logic [N_CH-1:0] pri_m, hi_m;
  logic [N_CH-1:0] pri_req, rr_req, rr_hi;
  logic            pri_found, hi_found, rr_found;
  logic [IW-1:0]   pri_idx, hi_idx, rr_idx;
  logic            adv;

  assign pri_n   = (IW+1)'(hybrid_arb_pkg::pri_span(mode_i, PRI_N1, PRI_N2, PRI_N3));
  assign base    = pri_n[IW-1:0];
  // pointer left below the round-robin group by a mode change starts at the group base
  assign ptr_eff = ({1'b0, ptr_q} < pri_n) ? base : ptr_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_mask
    assign pri_m[g]    = (IW+1)'(g) < pri_n;
    assign hi_m[g]     = IW'(g) >= ptr_eff;
    assign gnt_oh_o[g] = gnt_valid_o && (gnt_idx_o == IW'(g));
  end

  assign pri_req = req_i & pri_m;
  assign rr_req  = req_i & ~pri_m;
  assign rr_hi   = rr_req & hi_m;

  arb_first_set #(.W(N_CH)) u_pri (.vec_i(pri_req), .found_o(pri_found), .idx_o(pri_idx));
  arb_first_set #(.W(N_CH)) u_hi  (.vec_i(rr_hi),   .found_o(hi_found),  .idx_o(hi_idx));
  arb_first_set #(.W(N_CH)) u_rr  (.vec_i(rr_req),  .found_o(rr_found),  .idx_o(rr_idx));

  always_comb begin
    gnt_valid_o = pri_found || rr_found;
    if (pri_found)     gnt_idx_o = pri_idx;
    else if (hi_found) gnt_idx_o = hi_idx;
    else               gnt_idx_o = rr_idx;
  end

  assign adv = ack_i && gnt_valid_o && !pri_found;

  arb_rr_ptr #(.N_CH(N_CH)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .gnt_idx_i (gnt_idx_o),
    .base_i    (base),
    .ptr_o     (ptr_q)
  );
endmodule

// File: rtl/hybrid_arb_chk.sv
`timescale 1ns/1ps
module hybrid_arb_chk #(
  parameter int N_CH   = 256,
  parameter int PRI_N1 = 2,
  parameter int PRI_N2 = 16,
  parameter int PRI_N3 = 64,
  localparam int IW    = $clog2(N_CH)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      mode_i,
  input logic [N_CH-1:0] req_i,
  input logic            ack_i,
  input logic            gnt_valid_o,
  input logic [IW-1:0]   gnt_idx_o,
  input logic [N_CH-1:0] gnt_oh_o,
  input logic [IW-1:0]   ptr_q
);
  int              sp;
  logic            any_pri;
  logic [N_CH-1:0] below;
  logic            adv_d;
  logic [IW-1:0]   nxt_d, ptr_d;

  assign sp    = hybrid_arb_pkg::pri_span(mode_i, PRI_N1, PRI_N2, PRI_N3);
  assign below = (N_CH'(1) << gnt_idx_o) - N_CH'(1);

  always_comb begin
    any_pri = 1'b0;
    for (int i = 0; i < N_CH; i++) if (i < sp && req_i[i]) any_pri = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adv_d <= 1'b0;
      nxt_d <= '0;
      ptr_d <= '0;
    end else begin
      adv_d <= ack_i && gnt_valid_o && (int'(gnt_idx_o) >= sp);
      nxt_d <= (int'(gnt_idx_o) == N_CH - 1) ? IW'(sp) : gnt_idx_o + IW'(1);
      ptr_d <= ptr_q;
    end
  end

  AST_IDLE_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |-> (!gnt_valid_o && gnt_oh_o == '0)); // R9
  AST_GNT_ENCODING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> ($countones(gnt_oh_o) == 1 && gnt_oh_o[gnt_idx_o] && req_i[gnt_idx_o])); // R10
  AST_PRI_BEATS_RR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_pri |-> (gnt_valid_o && int'(gnt_idx_o) < sp)); // R6
  AST_PRI_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && int'(gnt_idx_o) < sp) |-> ((req_i & below) == '0)); // R5
  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_d |-> (ptr_q == nxt_d)); // R8
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_d |-> (ptr_q == ptr_d)); // R8
endmodule

bind hybrid_arb hybrid_arb_chk #(
  .N_CH(N_CH), .PRI_N1(PRI_N1), .PRI_N2(PRI_N2), .PRI_N3(PRI_N3)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .req_i       (req_i),
  .ack_i       (ack_i),
  .gnt_valid_o (gnt_valid_o),
  .gnt_idx_o   (gnt_idx_o),
  .gnt_oh_o    (gnt_oh_o),
  .ptr_q       (ptr_q)
);

// File: tb/sim_hybrid_arb.sv
`timescale 1ns/1ps
module sim_hybrid_arb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [255:0] req = '0;
  logic         ack = 1'b0;
  logic         gnt_valid;
  logic [7:0]   gnt_idx;
  logic [255:0] gnt_oh;

  int n_chk = 0;
  int n_fail = 0;
  int mptr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hybrid_arb u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .req_i(req), .ack_i(ack),
    .gnt_valid_o(gnt_valid), .gnt_idx_o(gnt_idx), .gnt_oh_o(gnt_oh)
  );

  function automatic int span(input logic [1:0] m);
    case (m)
      2'd1: return 2;
      2'd2: return 16;
      2'd3: return 64;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_grant(input logic [255:0] r, input logic [1:0] m, input int p);
    int n = span(m);
    int ep = (p < n) ? n : p;
    for (int i = 0; i < n; i++) if (r[i]) return i;
    for (int i = ep; i < 256; i++) if (r[i]) return i;
    for (int i = n; i < ep; i++) if (r[i]) return i;
    return -1;
  endfunction

  function automatic string auto_tag(input logic [1:0] m, input int e);
    if (e < 0) return "R9";
    if (e < span(m)) return "R5/R6";
    case (m)
      2'd0: return "R1/R7";
      2'd1: return "R2/R7";
      2'd2: return "R3/R7";
      default: return "R4/R7";
    endcase
  endfunction

  function automatic logic [255:0] bit1(input int i);
    logic [255:0] v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [255:0] rand256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic step(input logic [255:0] r, input logic [1:0] m, input logic a, input string tag);
    int e;
    logic [255:0] eoh;
    string t;
    @(negedge clk);
    req = r; mode = m; ack = a;
    #1;
    e = exp_grant(r, m, mptr);
    eoh = (e < 0) ? '0 : bit1(e);
    t = (tag == "") ? auto_tag(m, e) : tag;
    n_chk++;
    if (gnt_valid !== (e >= 0) || gnt_oh !== eoh || (e >= 0 && int'(gnt_idx) != e)) begin
      n_fail++;
      $display("FAIL %s (R10): valid=%0b idx=%0d ones=%0d, expected valid=%0b idx=%0d",
               t, gnt_valid, gnt_idx, $countones(gnt_oh), (e >= 0), e);
    end
    @(posedge clk);
    if (a && e >= span(m)) mptr = (e == 255) ? span(m) : e + 1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    step('0, 2'd0, 1'b0, "R9 reset idle");
    step('1, 2'd0, 1'b0, "R11 reset pointer");
    // R1: rotate through all-requesting round robin
    step('1, 2'd0, 1'b1, "R1");
    step('1, 2'd0, 1'b1, "R1");
    step('1, 2'd0, 1'b0, "R1");
    step(bit1(1) | bit1(5), 2'd1, 1'b0, "R2");
    step(bit1(0) | bit1(1), 2'd1, 1'b1, "R2 R5");
    step(bit1(2) | bit1(9), 2'd1, 1'b0, "R2 round-robin side");
    step(bit1(15) | bit1(16) | bit1(200), 2'd2, 1'b0, "R3 R6");
    step(bit1(63) | bit1(64), 2'd3, 1'b0, "R4 R6");
    step(bit1(64) | bit1(65), 2'd3, 1'b0, "R4 R7 pointer below group");
    // R7 / R8 wrap from the top index
    step(bit1(254), 2'd2, 1'b1, "R8 move to 255");
    step(bit1(255) | bit1(20), 2'd2, 1'b1, "R7 top");
    step(bit1(255) | bit1(20), 2'd2, 1'b0, "R8 wrap to base");
    step(bit1(255) | bit1(20), 2'd2, 1'b0, "R8 hold without ack");
    step(bit1(20) | bit1(25), 2'd2, 1'b1, "R8 advance past 20");
    step(bit1(3) | bit1(20), 2'd2, 1'b1, "R8 strict ack");
    step(bit1(20) | bit1(25), 2'd2, 1'b0, "R8 pointer held after strict ack");
    step('0, 2'd3, 1'b1, "R9 ack while idle");

    for (int it = 0; it < 6000; it++) begin
      logic [255:0] r;
      logic [1:0] m;
      case ($urandom % 6)
        0: r = rand256() & rand256() & rand256();
        1: r = rand256();
        2: r = '0;
        3: r = bit1($urandom % 256);
        4: r = rand256() & rand256() & rand256() & rand256() & {192'h0, 64'h0} | {rand256() & rand256() & rand256() & rand256()} & {{192{1'b1}}, 64'h0};
        default: r = bit1($urandom % 256) | bit1($urandom % 256) | bit1(255);
      endcase
      m = (($urandom % 16) == 0) ? 2'($urandom % 4) : mode;
      step(r, m, 1'($urandom % 2), "");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule